// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block is a memory-mapped peripheral with three independent count-up timers. Software reaches all of them through one synchronous register bus. Each timer has a power-of-two prescaler and a counter whose width is a parameter (16 or 32 bits). It also has an interval limit, two sticky event flags, a mask over those flags and one level interrupt output.

The registers of the three timers are interleaved at a 4-byte stride. Each counter runs in one of two modes:
- In free-running mode it wraps from the largest value back to zero and flags an overflow.
- In interval mode it restarts from zero on reaching the interval limit and flags an interval match.

Software acknowledges interrupts by reading the status register, which clears on read. A self-clearing restart bit sets the count back to zero at any time. Counting is paced by a shared count-enable input in the bus clock domain.

Top module: `tri_timer`

## Requirements
- R1: After reset, for every channel:
  - the clock-control register (channel base 0x00) reads 0;
  - the counter-control register (base 0x0C) reads 0x1, that is, disabled;
  - the counter-value register (base 0x18) reads 0;
  - the interval register (base 0x24) reads all ones for the counter width;
  - the status register (base 0x54) and the enable register (base 0x60) read 0;
  - every interrupt output is low.
- R2: Channel c (c = 0, 1, 2) uses each base offset plus 4·c. The clock-control bits 5:0 are stored and read back: bit 0 enables the prescaler, bits 4:1 hold N and bit 5 is the source select. Read data appears on `bus_rdata` in the cycle after the access.
- R3: With the prescaler off, each cycle with `cnt_en` high advances an enabled counter by one. With the prescaler on, the counter advances once per 2^(N+1) such cycles, counted from the last restart.
- R4: While counter-control bit 0 (disable) is 1, the counter and its prescaler hold their values.
- R5: Writing 1 to counter-control bit 4 sets the counter and the prescaler to zero. Bit 4 always reads back as 0, and counter-control reads show only bits 1:0.
- R6: In free-running mode (counter-control bit 1 = 0), the counter wraps from 2^W−1 to 0 and sets status bit 1 (overflow).
- R7: In interval mode (counter-control bit 1 = 1), the counter restarts at 0 on the tick on which it equals the interval value, and it sets status bit 0. After K ticks from a restart the count is K mod (I+1).
- R8: A status read returns the pending flags and clears them. An event that fires in the same cycle as the read stays pending.
- R9: A channel's interrupt output is high exactly when (status AND enable bits 1:0) is non-zero.
- R10: Writes to the counter-value register have no effect.
- R11: The channels are independent: configuring or counting one channel leaves the count and flags of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-enable pulse shared by the channels |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 3 | Level interrupt, one per channel |

## Verification
The embedded assertions check four rules on every cycle:
- a disabled counter does not move;
- a restart leaves the counter at zero;
- every event from the counter lands in the status flags, even under a simultaneous clearing read;
- the prescaler passes every enable through when it is off.

Only the bench scenarios can show the arithmetic:
- the counts after a given number of enabled cycles, swept over prescaler settings and interval values;
- the exact wrap point at 2^W−1;
- the address interleave between the channels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_CLKCTL = 8'h00;
  localparam int unsigned REG_CNTCTL = 8'h0C;
  localparam int unsigned REG_VALUE  = 8'h18;
  localparam int unsigned REG_INTV   = 8'h24;
  localparam int unsigned REG_STS    = 8'h54;
  localparam int unsigned REG_IEN    = 8'h60;
  localparam int unsigned CH_STRIDE  = 4;

  localparam int unsigned CCTL_DIS   = 0;
  localparam int unsigned CCTL_INTV  = 1;
  localparam int unsigned CCTL_RST   = 4;

  localparam int unsigned EV_INTV    = 0;
  localparam int unsigned EV_OVF     = 1;
  localparam int unsigned NUM_EV     = 2;

  typedef struct packed {
    logic       src_sel;
    logic [3:0] psc_exp;
    logic       psc_en;
  } clkctl_t;

  function automatic int unsigned reg_addr(int unsigned base, int unsigned ch);
    return base + CH_STRIDE * ch;
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             psc_on,
  input  logic [EXP_W-1:0] psc_exp,
  output logic             tick
);
  localparam int unsigned PW = 2 ** EXP_W;

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] limit;

  always_comb begin
    limit = {PW{1'b1}} >> (PW - 1 - psc_exp);
  end

  always_comb begin
    pcnt_d = pcnt_q;
    tick   = 1'b0;
    if (clr) begin
      pcnt_d = '0;
    end else if (en) begin
      if (!psc_on) begin
        tick = 1'b1;
      end else if (pcnt_q == limit) begin
        tick   = 1'b1;
        pcnt_d = '0;
      end else begin
        pcnt_d = pcnt_q + {{(PW-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3
  bypass_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !psc_on) |-> tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic         intv_mode,
  input  logic [W-1:0] intv,
  output logic [W-1:0] cnt,
  output logic         evt_intv,
  output logic         evt_ovf
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d    = cnt_q;
    evt_intv = 1'b0;
    evt_ovf  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (intv_mode && cnt_q == intv) begin
        cnt_d    = '0;
        evt_intv = 1'b1;
      end else if (!intv_mode && cnt_q == {W{1'b1}}) begin
        cnt_d   = '0;
        evt_ovf = 1'b1;
      end else begin
        cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !evt_intv && !evt_ovf) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CH     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              acc,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_val,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(reg_addr(REG_CLKCTL, CH));
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(reg_addr(REG_CNTCTL, CH));
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(reg_addr(REG_VALUE,  CH));
  localparam logic [ADDR_W-1:0] A_INTV = ADDR_W'(reg_addr(REG_INTV,   CH));
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(reg_addr(REG_STS,    CH));
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(reg_addr(REG_IEN,    CH));

  clkctl_t           clk_q, clk_d;
  logic              dis_q, dis_d;
  logic              mode_q, mode_d;
  logic [W-1:0]      intv_q, intv_d;
  logic [NUM_EV-1:0] sts_q, sts_d;
  logic [NUM_EV-1:0] ien_q, ien_d;

  logic              wr_clk, wr_ctl, wr_intv, wr_ien, rd_sts;
  logic              restart;
  logic              run_en, tick;
  logic [W-1:0]      cnt;
  logic              evt_intv, evt_ovf;
  logic [NUM_EV-1:0] evts;

  assign wr_clk  = acc && wr && (addr == A_CLK);
  assign wr_ctl  = acc && wr && (addr == A_CTL);
  assign wr_intv = acc && wr && (addr == A_INTV);
  assign wr_ien  = acc && wr && (addr == A_IEN);
  assign rd_sts  = acc && !wr && (addr == A_STS);
  assign restart = wr_ctl && wdata[CCTL_RST];
  assign run_en  = cnt_en && !dis_q;

  tmr_prescaler #(.EXP_W(4)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run_en),
    .clr     (restart),
    .psc_on  (clk_q.psc_en),
    .psc_exp (clk_q.psc_exp),
    .tick    (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr       (restart),
    .intv_mode (mode_q),
    .intv      (intv_q),
    .cnt       (cnt),
    .evt_intv  (evt_intv),
    .evt_ovf   (evt_ovf)
  );

  always_comb begin
    evts            = '0;
    evts[EV_INTV]   = evt_intv;
    evts[EV_OVF]    = evt_ovf;
  end

  always_comb begin
    clk_d  = clk_q;
    dis_d  = dis_q;
    mode_d = mode_q;
    intv_d = intv_q;
    ien_d  = ien_q;
    if (wr_clk) clk_d = clkctl_t'(wdata[5:0]);
    if (wr_ctl) begin
      dis_d  = wdata[CCTL_DIS];
      mode_d = wdata[CCTL_INTV];
    end
    if (wr_intv) intv_d = wdata[W-1:0];
    if (wr_ien)  ien_d  = wdata[NUM_EV-1:0];
    sts_d = (rd_sts ? '0 : sts_q) | evts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '0;
      dis_q  <= 1'b1;
      mode_q <= 1'b0;
      intv_q <= {W{1'b1}};
      sts_q  <= '0;
      ien_q  <= '0;
    end else begin
      clk_q  <= clk_d;
      dis_q  <= dis_d;
      mode_q <= mode_d;
      intv_q <= intv_d;
      sts_q  <= sts_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    rd_val = '0;
    if (acc && !wr) begin
      unique case (addr)
        A_CLK:   rd_val[5:0]        = clk_q;
        A_CTL:   rd_val[1:0]        = {mode_q, dis_q};
        A_VAL:   rd_val[W-1:0]      = cnt;
        A_INTV:  rd_val[W-1:0]      = intv_q;
        A_STS:   rd_val[NUM_EV-1:0] = sts_q;
        A_IEN:   rd_val[NUM_EV-1:0] = ien_q;
        default: rd_val             = '0;
      endcase
    end
  end

  assign irq = |(sts_q & ien_q);

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !restart) |=> $stable(cnt));

  // R8
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_intv || evt_ovf) |=> (sts_q[EV_INTV] || !$past(evt_intv)) && (sts_q[EV_OVF] || !$past(evt_ovf)));
endmodule

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int unsigned W      = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_CH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_CH-1:0]   irq
);
  logic        rst_n_s;
  logic [31:0] ch_rd [N_CH];
  logic [31:0] rd_any;
  logic [31:0] rdata_q;

  tmr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tmr_channel #(.W(W), .ADDR_W(ADDR_W), .CH(c)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .cnt_en (cnt_en),
      .acc    (bus_sel),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .rd_val (ch_rd[c]),
      .irq    (irq[c])
    );
  end

  always_comb begin
    rd_any = '0;
    for (int c = 0; c < N_CH; c++) rd_any = rd_any | ch_rd[c];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)                rdata_q <= '0;
    else if (bus_sel && !bus_wr) rdata_q <= rd_any;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: tb/tri_timer_bench.sv
module tri_timer_bench;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tri_timer u_tri_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int base, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(base + 4*ch); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(int ch, int base, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(base + 4*ch);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(int k);
    @(negedge clk);
    for (int i = 0; i < k; i++) begin
      cnt_en = 1'b1;
      @(negedge clk);
    end
    cnt_en = 1'b0;
  endtask

  initial begin
    #5_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    for (int c = 0; c < 3; c++) begin
      rd(c, 8'h00, v); check("R1 clkctl", v, 0);
      rd(c, 8'h0C, v); check("R1 cntctl", v, 1);
      rd(c, 8'h18, v); check("R1 value", v, 0);
      rd(c, 8'h24, v); check("R1 interval", v, 32'hFFFF);
      rd(c, 8'h54, v); check("R1 status", v, 0);
      rd(c, 8'h60, v); check("R1 enable", v, 0);
    end
    check("R1 irq", {29'd0, irq}, 0);

    // R2 clock-control readback and stride
    for (int c = 0; c < 3; c++) wr(c, 8'h00, 32'(6'h15 + c));
    for (int c = 0; c < 3; c++) begin rd(c, 8'h00, v); check("R2 clkctl", v, 32'(6'h15 + c)); end
    wr(1, 8'h00, 32'hFFFF_FF3F); rd(1, 8'h00, v); check("R2 six bits", v, 32'h3F);
    for (int c = 0; c < 3; c++) wr(c, 8'h00, 0);

    // R4 disabled counter holds
    pulse(10); rd(0, 8'h18, v); check("R4 hold", v, 0);

    // R3 no prescale, then prescale sweep
    for (int k = 0; k < 20; k += 3) begin
      wr(0, 8'h0C, 32'h10); pulse(k); rd(0, 8'h18, v); check("R3 direct", v, k);
    end
    for (int n = 0; n < 4; n++) begin
      wr(0, 8'h00, 32'((n << 1) | 1));
      for (int k = 0; k < 40; k += 7) begin
        wr(0, 8'h0C, 32'h10); pulse(k); rd(0, 8'h18, v);
        check("R3 prescaled", v, k / (1 << (n + 1)));
      end
    end
    wr(0, 8'h00, 0);

    // R4 disable mid-count, R5 restart, reset bit reads 0
    wr(0, 8'h0C, 32'h10); pulse(5);
    wr(0, 8'h0C, 32'h01); pulse(7); rd(0, 8'h18, v); check("R4 hold mid", v, 5);
    rd(0, 8'h0C, v); check("R5 bit4 reads 0", v, 1);
    wr(0, 8'h0C, 32'h11); rd(0, 8'h18, v); check("R5 restart zero", v, 0);

    // R10 value write ignored
    wr(0, 8'h0C, 32'h10); pulse(3);
    wr(0, 8'h18, 32'h55); rd(0, 8'h18, v); check("R10 value write", v, 3);

    // R7 interval sweep, R8 clear-on-read, R9 irq
    wr(0, 8'h60, 32'h1);
    for (int iv = 0; iv < 6; iv++) begin
      wr(0, 8'h24, iv);
      for (int k = 0; k < 13; k += 2) begin
        wr(0, 8'h0C, 32'h12); rd(0, 8'h54, v);
        pulse(k);
        rd(0, 8'h18, v); check("R7 count", v, k % (iv + 1));
        check("R9 irq", {31'd0, irq[0]}, (k > iv) ? 1 : 0);
        rd(0, 8'h54, v); check("R7 status", v, (k > iv) ? 1 : 0);
        rd(0, 8'h54, v); check("R8 cleared", v, 0);
        check("R9 irq low", {31'd0, irq[0]}, 0);
      end
    end
    wr(0, 8'h60, 32'h2); wr(0, 8'h24, 2); wr(0, 8'h0C, 32'h12); pulse(4);
    check("R9 masked", {31'd0, irq[0]}, 0);
    rd(0, 8'h54, v);

    // R8 read in the same cycle as an event
    wr(0, 8'h24, 0); wr(0, 8'h0C, 32'h12); pulse(1);
    @(negedge clk);
    cnt_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h54;
    @(negedge clk);
    cnt_en = 1'b0; bus_sel = 1'b0;
    check("R8 read value", bus_rdata, 1);
    rd(0, 8'h54, v); check("R8 simultaneous event kept", v, 1);
    wr(0, 8'h0C, 32'h01);

    // R11 independence: count channel 2 while 0 and 1 are off
    wr(2, 8'h0C, 32'h10); pulse(9);
    rd(2, 8'h18, v); check("R11 ch2 count", v, 9);
    rd(1, 8'h18, v); check("R11 ch1 untouched", v, 0);
    rd(1, 8'h54, v); check("R11 ch1 status", v, 0);
    wr(2, 8'h0C, 32'h01);

    // R6 free-running wrap on channel 1
    wr(1, 8'h60, 32'h2); wr(1, 8'h0C, 32'h10);
    pulse(65535);
    rd(1, 8'h18, v); check("R6 at max", v, 32'hFFFF);
    rd(1, 8'h54, v); check("R6 no flag yet", v, 0);
    pulse(1);
    check("R9 overflow irq", {29'd0, irq}, 3'b010);
    rd(1, 8'h18, v); check("R6 wrapped", v, 0);
    rd(1, 8'h54, v); check("R6 overflow flag", v, 2);
    rd(0, 8'h54, v); check("R11 ch0 no flag", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule